// File: doc/BRIEF.md
# Mode-Selectable Four-Tap Streaming FIR Filter

This block filters a stream of signed 8-bit samples with a four-tap finite impulse response. Each cycle in which the input strobe is high, one sample enters. The block multiplies the newest sample and the three samples accepted before it by four signed coefficients, all in parallel, and adds the products. The result appears a fixed two clocks later, marked by an output strobe. Gaps in the input stream do not disturb the history: the delay line advances only on accepted samples.

A mode register picks where the coefficients come from. Four modes use built-in weight sets: pass-through, a four-point average, a binomial-style low-pass and a first-difference high-pass. The averaging modes scale the sum down by an arithmetic right shift. A fifth mode uses four coefficients written over a small write port. Coefficient writes only land in a staging copy. They reach the datapath together, as one set, when the mode register is written. A reprogramming sequence therefore never filters with a half-old, half-new coefficient set.

Top module: `fir4_stream`

## Requirements
- R1: While reset is low and right after it, out_vld is 0 and out_data is 0. The delay history is all zero, the mode is 0 (pass-through) and the committed user coefficients are zero.
- R2: For a sample accepted with in_vld high, the result before scaling is c0*x[n] + c1*x[n-1] + c2*x[n-2] + c3*x[n-3]. Here x[n] is that sample, x[n-k] is the sample accepted k strobes earlier, and all values are signed two's complement.
- R3: out_vld is 1 exactly in the cycles two clock edges after a cycle with in_vld high. out_data carries that sample's result in those cycles.
- R4: When in_vld is low the delay history does not move. In any cycle with out_vld low, out_data keeps its previous value.
- R5: Mode codes: 0 gives weights {1,0,0,0} with no shift. 1 gives {1,1,1,1} with the sum shifted right arithmetically by 2. 2 gives {1,3,3,1}, shifted right by 3. 3 gives {1,-1,0,0} with no shift. 4 gives the committed user coefficients with no shift. Codes 5, 6 and 7 act as code 0.
- R6: A write is a single cycle with wr_en high. Addresses 0 to 3 stage c0 to c3 from wr_data (signed 8-bit). Address 4 loads the mode from wr_data[2:0] and commits all four staged coefficients at the same time. Addresses 5 to 7 change nothing.
- R7: Staged coefficients have no effect on any output until a write to address 4 commits them, even while mode 4 is active.
- R8: A mode or commit write acts on samples accepted in later cycles. A sample accepted in the same cycle as the write is filtered with the previous setting.
- R9: Accumulation is 18-bit signed with no saturation. The extreme case of four -128 coefficients against four -128 samples gives +65536.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Sample strobe |
| in_data | input | 8 | Signed input sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0-3 coefficients, 4 mode and commit) |
| wr_data | input | 8 | Write value |
| out_vld | output | 1 | Result strobe, two edges after the sample |
| out_data | output | 18 | Signed filtered result after the mode's shift |

## Verification
The bench aims at the first outputs after reset. A design that forgot to clear the history would leak stale samples into them, or would start in a mode other than pass-through. It feeds gapped input streams: a history that shifts on idle cycles, or a strobe that is not tied to the input, shows up as wrong products or a wrong out_vld pattern. It stages coefficients without committing them, and also writes a mode in the very cycle a sample arrives, so an unbuffered coefficient path or an off-by-one application edge gives different numbers. Negative extremes and the averaging modes expose a logical shift used where an arithmetic one belongs, or an accumulator too narrow to hold +65536.

// File: rtl/fir4_pkg.sv
package fir4_pkg;

  localparam int MODE_W  = 3;
  localparam int SHIFT_W = 2;

  localparam logic [MODE_W-1:0] M_PASS = 3'd0;
  localparam logic [MODE_W-1:0] M_AVG  = 3'd1;
  localparam logic [MODE_W-1:0] M_LPF  = 3'd2;
  localparam logic [MODE_W-1:0] M_HPF  = 3'd3;
  localparam logic [MODE_W-1:0] M_USER = 3'd4;

  // Built-in weight of one tap for a mode; unknown codes fall back to pass-through.
  function automatic int preset_weight(input logic [MODE_W-1:0] mode, input int tap);
    int w;
    w = 0;
    case (mode)
      M_AVG: w = (tap < 4) ? 1 : 0;
      M_LPF: begin
        case (tap)
          0, 3:    w = 1;
          1, 2:    w = 3;
          default: w = 0;
        endcase
      end
      M_HPF: begin
        if (tap == 0)      w = 1;
        else if (tap == 1) w = -1;
        else               w = 0;
      end
      default: w = (tap == 0) ? 1 : 0;
    endcase
    return w;
  endfunction

  // Right shift applied to the accumulated sum for a mode.
  function automatic logic [SHIFT_W-1:0] preset_shift(input logic [MODE_W-1:0] mode);
    logic [SHIFT_W-1:0] s;
    case (mode)
      M_AVG:   s = 2'd2;
      M_LPF:   s = 2'd3;
      default: s = 2'd0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/fir4_cfg.sv
module fir4_cfg
  import fir4_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int COEF_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [COEF_W-1:0]              wr_data,
  output logic [MODE_W-1:0]              mode_q,
  output logic [TAPS-1:0][COEF_W-1:0]    user_act,
  output logic                           commit_evt
);

  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(TAPS);

  logic [TAPS-1:0][COEF_W-1:0] user_stage;
  logic [TAPS-1:0]             stage_hit;

  assign commit_evt = wr_en && (wr_addr == MODE_ADDR);

  for (genvar t = 0; t < TAPS; t++) begin : g_hit
    assign stage_hit[t] = wr_en && (wr_addr == ADDR_W'(t));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      user_stage <= '0;
      user_act   <= '0;
      mode_q     <= M_PASS;
    end else begin
      for (int t = 0; t < TAPS; t++) begin
        if (stage_hit[t]) user_stage[t] <= wr_data;
      end
      if (commit_evt) begin
        mode_q   <= wr_data[MODE_W-1:0];
        user_act <= user_stage;
      end
    end
  end

endmodule

// File: rtl/fir4_delay.sv
module fir4_delay #(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_vld,
  input  logic [DATA_W-1:0]             in_data,
  output logic [TAPS-1:0][DATA_W-1:0]   taps
);

  logic [TAPS-2:0][DATA_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (in_vld) begin
      hist[0] <= in_data;
      for (int i = 1; i < TAPS - 1; i++) hist[i] <= hist[i-1];
    end
  end

  // taps[0] is the sample arriving now, taps[k] the one accepted k strobes ago.
  assign taps = {hist, in_data};

endmodule

// File: rtl/fir4_mac.sv
module fir4_mac
  import fir4_pkg::*;
#(
  parameter int TAPS   = 4,
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_vld,
  input  logic [TAPS-1:0][DATA_W-1:0]   taps,
  input  logic [TAPS-1:0][COEF_W-1:0]   coefs,
  input  logic [SHIFT_W-1:0]            shift,
  output logic                          vld1,
  output logic                          out_vld,
  output logic signed [ACC_W-1:0]       out_data
);

  localparam int PROD_W = DATA_W + COEF_W;

  logic [TAPS-1:0][PROD_W-1:0] prod_q;
  logic [SHIFT_W-1:0]          shift_q;
  logic signed [ACC_W-1:0]     sum_comb;

  function automatic logic signed [PROD_W-1:0] tap_mul(
    input logic signed [DATA_W-1:0] x,
    input logic signed [COEF_W-1:0] c
  );
    return x * c;
  endfunction

  function automatic logic signed [ACC_W-1:0] tree_sum(
    input logic [TAPS-1:0][PROD_W-1:0] p
  );
    logic signed [ACC_W-1:0] acc;
    acc = '0;
    for (int i = 0; i < TAPS; i++) begin
      acc = acc + {{(ACC_W-PROD_W){p[i][PROD_W-1]}}, p[i]};
    end
    return acc;
  endfunction

  assign sum_comb = tree_sum(prod_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q  <= '0;
      shift_q <= '0;
      vld1    <= 1'b0;
    end else begin
      vld1 <= in_vld;
      if (in_vld) begin
        for (int i = 0; i < TAPS; i++) begin
          prod_q[i] <= tap_mul(taps[i], coefs[i]);
        end
        shift_q <= shift;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      out_vld <= vld1;
      if (vld1) out_data <= sum_comb >>> shift_q;
    end
  end

endmodule

// File: rtl/fir4_stream.sv
module fir4_stream
  import fir4_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8,
  parameter int TAPS   = 4,
  parameter int ACC_W  = 18,
  parameter int ADDR_W = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_vld,
  input  logic [DATA_W-1:0]        in_data,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [COEF_W-1:0]        wr_data,
  output logic                     out_vld,
  output logic signed [ACC_W-1:0]  out_data
);

  logic [MODE_W-1:0]            mode_q;
  logic [TAPS-1:0][COEF_W-1:0]  user_act;
  logic                         commit_evt;
  logic [TAPS-1:0][DATA_W-1:0]  taps;
  logic [TAPS-1:0][COEF_W-1:0]  coef_sel;
  logic [SHIFT_W-1:0]           shift_sel;
  logic                         vld1;
  logic                         user_mode;

  fir4_cfg #(.TAPS(TAPS), .COEF_W(COEF_W), .ADDR_W(ADDR_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .mode_q     (mode_q),
    .user_act   (user_act),
    .commit_evt (commit_evt)
  );

  fir4_delay #(.TAPS(TAPS), .DATA_W(DATA_W)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_vld  (in_vld),
    .in_data (in_data),
    .taps    (taps)
  );

  assign user_mode = (mode_q == M_USER);
  assign shift_sel = user_mode ? '0 : preset_shift(mode_q);

  for (genvar t = 0; t < TAPS; t++) begin : g_coef
    assign coef_sel[t] = user_mode ? user_act[t] : COEF_W'(preset_weight(mode_q, t));
  end

  fir4_mac #(.TAPS(TAPS), .DATA_W(DATA_W), .COEF_W(COEF_W), .ACC_W(ACC_W)) u_mac (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (in_vld),
    .taps     (taps),
    .coefs    (coef_sel),
    .shift    (shift_sel),
    .vld1     (vld1),
    .out_vld  (out_vld),
    .out_data (out_data)
  );

endmodule

// File: rtl/fir4_stream_chk.sv
module fir4_stream_chk #(
  parameter int TAPS   = 4,
  parameter int COEF_W = 8,
  parameter int ACC_W  = 18,
  parameter int ADDR_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_vld,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic                    out_vld,
  input logic [ACC_W-1:0]        out_data,
  input logic [2:0]              mode_q,
  input logic [TAPS*COEF_W-1:0]  user_act
);

  logic [1:0] cyc;
  logic       mode_wr;

  assign mode_wr = wr_en && (wr_addr == ADDR_W'(TAPS));

  always_ff @(posedge clk) begin
    if (!rst_n)          cyc <= '0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  AST_LAT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> ##1 out_vld); // R3
  AST_LAT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc >= 2'd2 && out_vld) |-> $past(in_vld, 2)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc != 2'd0 && !out_vld) |-> $stable(out_data)); // R4
  AST_MODE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(mode_q)); // R6
  AST_USER_SET_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr |=> $stable(user_act)); // R7

endmodule

bind fir4_stream fir4_stream_chk #(
  .TAPS(TAPS), .COEF_W(COEF_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_vld   (in_vld),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .out_vld  (out_vld),
  .out_data (out_data),
  .mode_q   (mode_q),
  .user_act (user_act)
);

// File: tb/test_fir4_stream.sv
module test_fir4_stream;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [7:0]  in_data = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        out_vld;
  logic [17:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural reference state
  int hist[$];
  int m_mode;
  int stg[4];
  int act[4];
  bit s1v, s2v;
  int s1d, s2d;

  always #2 clk = ~clk;

  fir4_stream i_fir4_stream (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_vld(out_vld), .out_data(out_data)
  );

  function automatic int weight(int mode, int t);
    case (mode)
      1: return 1;
      2: return (t == 0 || t == 3) ? 1 : 3;
      3: return (t == 0) ? 1 : ((t == 1) ? -1 : 0);
      4: return act[t];
      default: return (t == 0) ? 1 : 0;
    endcase
  endfunction

  function automatic int scale(int mode);
    if (mode == 1) return 2;
    if (mode == 2) return 3;
    return 0;
  endfunction

  task automatic model_reset();
    hist = {0, 0, 0};
    m_mode = 0;
    for (int i = 0; i < 4; i++) begin stg[i] = 0; act[i] = 0; end
    s1v = 0; s2v = 0; s1d = 0; s2d = 0;
  endtask

  task automatic compare(string tag);
    int got;
    got = $signed(out_data);
    n_cmp++;
    if (out_vld !== s2v || got != s2d) begin
      n_bad++;
      $display("FAIL %s: actual vld=%0b data=%0d expected vld=%0b data=%0d",
               tag, out_vld, got, s2v, s2d);
    end
  endtask

  // one clock: drive, let the edge happen, update the model, compare at negedge
  task automatic step(bit v, int d, bit we, int a, int wd, string tag);
    int y;
    int xs[4];
    in_vld = v; in_data = 8'(d); wr_en = we; wr_addr = 3'(a); wr_data = 8'(wd);
    @(posedge clk);
    y = 0;
    if (v) begin
      xs[0] = d; xs[1] = hist[0]; xs[2] = hist[1]; xs[3] = hist[2];
      for (int i = 0; i < 4; i++) y += weight(m_mode, i) * xs[i];
      y = y >>> scale(m_mode);
    end
    if (s1v) s2d = s1d;
    s2v = s1v;
    s1v = v;
    if (v) begin
      s1d = y;
      hist.push_front(d);
      void'(hist.pop_back());
    end
    if (we) begin
      if (a < 4) stg[a] = $signed(8'(wd));
      else if (a == 4) begin
        m_mode = wd & 7;
        for (int i = 0; i < 4; i++) act[i] = stg[i];
      end
    end
    @(negedge clk);
    compare(tag);
  endtask

  task automatic feed(int d, string tag);
    step(1, d, 0, 0, 0, tag);
  endtask

  task automatic wr(int a, int wd, string tag);
    step(0, 0, 1, a, wd, tag);
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, tag);
  endtask

  task automatic pattern(string tag);
    int seq[7] = '{10, -20, 35, 127, -128, 5, -1};
    foreach (seq[i]) feed(seq[i], tag);
    drain(tag);
  endtask

  initial begin
    model_reset();
    // R1: reset state observed while reset is held
    repeat (3) begin
      @(negedge clk);
      compare("R1");
    end
    rst_n = 1'b1;
    // R1, R5: pass-through impulse straight after reset, zero history
    feed(100, "R1");
    feed(0, "R1");
    feed(0, "R1");
    drain("R1");
    // R4: gapped stream, history must not move on idle cycles
    step(1, 7, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R4");
    step(1, -9, 0, 0, 0, "R4");
    wr(4, 3, "R4");
    step(1, 50, 0, 0, 0, "R4");
    step(0, 0, 0, 0, 0, "R4");
    step(1, 60, 0, 0, 0, "R4");
    drain("R4");
    // R5: every mode code, including the three that fall back
    for (int m = 0; m < 8; m++) begin
      wr(4, m, "R5");
      pattern("R5");
    end
    // R6: stage and commit user coefficients
    wr(0, 2, "R6"); wr(1, -3, "R6"); wr(2, 4, "R6"); wr(3, -5, "R6");
    wr(4, 4, "R6");
    pattern("R6");
    // R6: addresses 5..7 change nothing
    wr(5, 1, "R6"); wr(6, 2, "R6"); wr(7, 3, "R6");
    pattern("R6");
    // R7: staged but uncommitted values leave the output alone
    wr(0, 9, "R7"); wr(1, 9, "R7"); wr(2, 9, "R7");
    pattern("R7");
    wr(3, 9, "R7");
    wr(4, 4, "R7");
    pattern("R7");
    // R8: write in the same cycle as a sample acts from the next sample on
    wr(4, 0, "R8");
    feed(40, "R8");
    step(1, 80, 1, 4, 1, "R8");
    feed(-12, "R8");
    step(1, 33, 1, 4, 3, "R8");
    feed(33, "R8");
    drain("R8");
    // R9: widest magnitudes through the accumulator
    for (int i = 0; i < 4; i++) wr(i, -128, "R9");
    wr(4, 4, "R9");
    for (int i = 0; i < 5; i++) feed(-128, "R9");
    for (int i = 0; i < 4; i++) feed(127, "R9");
    drain("R9");
    wr(4, 1, "R9");
    for (int i = 0; i < 5; i++) feed(-128, "R9");
    drain("R9");
    // R2: random stream with random reconfiguration
    for (int i = 0; i < 400; i++) begin
      bit v, we;
      int a;
      v  = ($urandom_range(0, 3) != 0);
      we = ($urandom_range(0, 9) == 0);
      a  = $urandom_range(0, 7);
      step(v, $urandom_range(0, 255) - 128, we, a,
           (a == 4) ? $urandom_range(0, 7) : $urandom_range(0, 255) - 128, "R2");
    end
    drain("R2");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #400000ns;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=still running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule